// File: doc/BRIEF.md
# Address-Coded Register File with Shared ALU

This block is a bus slave that holds sixteen 16-bit registers behind one shared arithmetic/logic unit. The slave answers to a 256-word window chosen by a base parameter. Inside that window the low address byte carries two 4-bit fields: an operation code and a register index.

A store never simply overwrites a register. On each clock edge where the write strobe is high and the address hits the window, the selected register is replaced by the ALU result. The ALU's first operand is the register's present contents and its second operand is the word on the data bus. Software can therefore add, mask, shift or clear a register with a single bus write by choosing the address.

A read is combinational. While the read strobe is high and the address hits, the selected register drives the shared tristate data bus. The operation field is ignored on a read. At all other times the block leaves the bus floating.

Top module: `alu_regbank`

## Requirements
- R1: After the active-low asynchronous reset, every register reads back as 0x0000.
- R2: The block responds only when address bits 15..8 equal the BASE_ADDR parameter. Address bits 7..4 are the operation code and bits 3..0 are the register index. A write outside the window changes no register.
- R3: On every rising clock edge with write high and a hit, register[index] becomes f(a, b) and all other registers are unchanged. Here a is register[index] before the edge and b is the data bus. A write held for two edges applies the operation twice.
- R4: Arithmetic codes wrap modulo 2^16: 0 gives b, 1 gives a+b, 2 gives a-b, 3 gives b-a, 9 gives a+1 and 10 gives a-1.
- R5: Bitwise codes: 4 gives a AND b, 5 gives a OR b, 6 gives a XOR b, 7 gives a AND NOT b, and 8 gives NOT b.
- R6: Shift codes act on a by one place: 11 shifts left with zero fill, 12 shifts right with zero fill, and 13 shifts right while copying bit 15.
- R7: Code 14 leaves the register unchanged, whatever the bus data. Code 15 sets the register to zero.
- R8: While read is high and the address hits, the data bus carries register[index], whatever the operation field holds, and the read alters no register.
- R9: While read is low, or the address misses, the block does not drive the data bus (high impedance).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address: base, operation, index |
| wr_i | input | 1 | Write strobe, sampled on the rising edge |
| rd_i | input | 1 | Read strobe, combinational bus enable |
| data_io | inout | 16 | Shared tristate data bus |

## Verification
The bench walks every one of the sixteen operation codes against operands chosen to expose wrong behaviour. These operands include subtraction that underflows, a right shift of a word with bit 15 set, and increment and decrement across the 16-bit wrap. A design that swapped a-b with b-a, or that filled the wrong bit on a shift, gives a wrong read-back value. A write to a neighbouring base must leave every register intact, and a write held for two edges must show a doubled increment. A read with the clear code in its address must return the data untouched. A design that failed to float the bus outside a hit would show a driven value where the bench expects high impedance.

// File: rtl/alu_regbank_pkg.sv
package alu_regbank_pkg;
  typedef enum logic [3:0] {
    OP_PASS_B = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB_AB = 4'd2,
    OP_SUB_BA = 4'd3,
    OP_AND    = 4'd4,
    OP_OR     = 4'd5,
    OP_XOR    = 4'd6,
    OP_ANDN   = 4'd7,
    OP_NOT_B  = 4'd8,
    OP_INC    = 4'd9,
    OP_DEC    = 4'd10,
    OP_SHL    = 4'd11,
    OP_SHR    = 4'd12,
    OP_ASR    = 4'd13,
    OP_PASS_A = 4'd14,
    OP_CLR    = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_regbank_decode.sv
module alu_regbank_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned BASE_W = ADDR_W - OP_W - IDX_W,
  parameter logic [BASE_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [OP_W-1:0]   op_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned OP_LSB = IDX_W;

  assign hit_o = (addr_i[ADDR_W-1 -: BASE_W] == BASE_ADDR);
  assign op_o  = addr_i[OP_LSB +: OP_W];
  assign idx_o = addr_i[IDX_W-1:0];
endmodule

// File: rtl/alu_regbank_alu.sv
module alu_regbank_alu
  import alu_regbank_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] f_o
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (op_i)
      OP_PASS_B: f_o = b_i;
      OP_ADD:    f_o = a_i + b_i;
      OP_SUB_AB: f_o = a_i - b_i;
      OP_SUB_BA: f_o = b_i - a_i;
      OP_AND:    f_o = a_i & b_i;
      OP_OR:     f_o = a_i | b_i;
      OP_XOR:    f_o = a_i ^ b_i;
      OP_ANDN:   f_o = a_i & ~b_i;
      OP_NOT_B:  f_o = ~b_i;
      OP_INC:    f_o = a_i + ONE;
      OP_DEC:    f_o = a_i - ONE;
      OP_SHL:    f_o = {a_i[W-2:0], 1'b0};
      OP_SHR:    f_o = {1'b0, a_i[W-1:1]};
      OP_ASR:    f_o = {a_i[W-1], a_i[W-1:1]};
      OP_PASS_A: f_o = a_i;
      OP_CLR:    f_o = '0;
      default:   f_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_regbank_regfile.sv
module alu_regbank_regfile #(
  parameter int unsigned W = 16,
  parameter int unsigned N = 16,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IW-1:0]     idx_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar g = 0; g < N; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs_o[g] <= '0;
      else if (we_i && (idx_i == IW'(g)))    regs_o[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_o[idx_i];
endmodule

// File: rtl/alu_regbank.sv
module alu_regbank
  import alu_regbank_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned OP_W     = 4,
  parameter logic [7:0]  BASE_ADDR = 8'hC3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  inout  wire  [DATA_W-1:0] data_io
);
  localparam int unsigned IDX_W  = $clog2(NUM_REGS);
  localparam int unsigned BASE_W = ADDR_W - OP_W - IDX_W;

  logic                          hit;
  logic [OP_W-1:0]               op_raw;
  logic [IDX_W-1:0]              idx;
  logic [DATA_W-1:0]             reg_a;
  logic [DATA_W-1:0]             alu_f;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic                          bus_oe;

  alu_regbank_decode #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .IDX_W(IDX_W), .BASE_W(BASE_W),
    .BASE_ADDR(BASE_W'(BASE_ADDR))
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .op_o(op_raw), .idx_o(idx)
  );

  alu_regbank_alu #(.W(DATA_W)) u_alu (
    .op_i(alu_op_e'(op_raw)), .a_i(reg_a), .b_i(data_io), .f_o(alu_f)
  );

  alu_regbank_regfile #(.W(DATA_W), .N(NUM_REGS)) u_rf (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(wr_i && hit), .idx_i(idx), .wdata_i(alu_f),
    .rdata_o(reg_a), .regs_o(regs_q)
  );

  assign bus_oe  = rd_i && hit;
  assign data_io = bus_oe ? reg_a : {DATA_W{1'bz}};
endmodule

// File: rtl/alu_regbank_chk.sv
module alu_regbank_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned NUM_REGS = 16,
  parameter logic [7:0]  BASE_ADDR = 8'hC3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [ADDR_W-1:0]             addr_i,
  input logic                          wr_i,
  input logic                          rd_i,
  input logic [DATA_W-1:0]             data_io,
  input logic                          bus_oe,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  logic          in_win;
  logic [3:0]    opc;
  logic [IDX_W-1:0] ix;
  assign in_win = (addr_i[ADDR_W-1 -: 8] == BASE_ADDR);
  assign opc    = addr_i[IDX_W +: 4];
  assign ix     = addr_i[IDX_W-1:0];

  // R2
  no_write_no_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && in_win) |=> $stable(regs_q));
  // R4
  pass_b_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_win && opc == 4'd0) |=> regs_q[$past(ix)] == $past(data_io));
  // R7
  clear_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_win && opc == 4'd15) |=> regs_q[$past(ix)] == '0);
  // R7
  pass_a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && in_win && opc == 4'd14) |=> $stable(regs_q));
  // R8
  read_drives_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && in_win && !wr_i) |-> data_io == regs_q[ix]);
  // R9
  float_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && in_win) |-> !bus_oe);
endmodule

bind alu_regbank alu_regbank_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .data_io(data_io), .bus_oe(bus_oe), .regs_q(regs_q)
);

// File: tb/tb_alu_regbank.sv
module tb_alu_regbank;
  localparam logic [7:0] BASE = 8'hC3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] drv = '0;
  logic        drv_en = 1'b0;
  wire  [15:0] bus;
  int checks = 0;
  int fails  = 0;
  logic [15:0] model [16];

  assign bus = drv_en ? drv : 16'hzzzz;
  always #5 clk = ~clk;

  alu_regbank #(.BASE_ADDR(BASE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd), .data_io(bus)
  );

  function automatic logic [15:0] ref_op(input logic [3:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      4'd0: return b;           4'd1: return a + b;
      4'd2: return a - b;       4'd3: return b - a;
      4'd4: return a & b;       4'd5: return a | b;
      4'd6: return a ^ b;       4'd7: return a & ~b;
      4'd8: return ~b;          4'd9: return a + 16'd1;
      4'd10: return a - 16'd1;  4'd11: return {a[14:0], 1'b0};
      4'd12: return {1'b0, a[15:1]};
      4'd13: return {a[15], a[15:1]};
      4'd14: return a;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] base, input logic [3:0] op, input logic [3:0] idx,
                           input logic [15:0] d, input int cycles);
    @(negedge clk);
    addr = {base, op, idx}; drv = d; drv_en = 1'b1; wr = 1'b1;
    repeat (cycles) @(negedge clk);
    wr = 1'b0; drv_en = 1'b0;
    if (base == BASE)
      for (int i = 0; i < cycles; i++) model[idx] = ref_op(op, model[idx], d);
  endtask

  task automatic bus_read(input logic [3:0] op, input logic [3:0] idx, output logic [15:0] q);
    @(negedge clk);
    addr = {BASE, op, idx}; rd = 1'b1;
    #1 q = bus;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic op_case(input string req, input logic [3:0] op, input logic [3:0] idx,
                         input logic [15:0] a, input logic [15:0] b);
    logic [15:0] q;
    bus_write(BASE, 4'd0, idx, a, 1);
    bus_write(BASE, op, idx, b, 1);
    bus_read(4'd0, idx, q);
    check(req, q, ref_op(op, a, b));
  endtask

  task automatic t_reset();
    logic [15:0] q;
    logic [15:0] acc = '0;
    for (int i = 0; i < 16; i++) begin
      bus_read(4'd0, 4'(i), q);
      acc |= q;
    end
    check("R1 all registers zero after reset", acc, 16'h0000);
  endtask

  task automatic t_window();
    logic [15:0] q;
    bus_write(BASE, 4'd0, 4'd5, 16'h1234, 1);
    bus_write(BASE ^ 8'h01, 4'd0, 4'd5, 16'hDEAD, 1);
    bus_write(BASE ^ 8'h80, 4'd15, 4'd5, 16'h0000, 1);
    bus_read(4'd0, 4'd5, q);
    check("R2 miss-window write ignored", q, 16'h1234);
  endtask

  task automatic t_select();
    logic [15:0] q;
    bus_write(BASE, 4'd0, 4'd3, 16'hAAAA, 1);
    bus_write(BASE, 4'd0, 4'd4, 16'h5555, 1);
    bus_write(BASE, 4'd1, 4'd3, 16'h0001, 1);
    bus_read(4'd0, 4'd4, q);
    check("R3 neighbour untouched", q, 16'h5555);
    bus_read(4'd0, 4'd3, q);
    check("R3 selected register updated", q, 16'hAAAB);
    bus_write(BASE, 4'd9, 4'd3, 16'h0000, 2);
    bus_read(4'd0, 4'd3, q);
    check("R3 held write applies twice", q, 16'hAAAD);
  endtask

  task automatic t_arith();
    op_case("R4 pass b", 4'd0, 4'd1, 16'h7777, 16'h0F0F);
    op_case("R4 add wrap", 4'd1, 4'd1, 16'hFFF0, 16'h0020);
    op_case("R4 a-b underflow", 4'd2, 4'd2, 16'h0003, 16'h0005);
    op_case("R4 b-a", 4'd3, 4'd2, 16'h0003, 16'h0005);
    op_case("R4 inc wrap", 4'd9, 4'd6, 16'hFFFF, 16'h1234);
    op_case("R4 dec wrap", 4'd10, 4'd6, 16'h0000, 16'h1234);
  endtask

  task automatic t_logic();
    op_case("R5 and", 4'd4, 4'd7, 16'hF0F0, 16'hFF00);
    op_case("R5 or", 4'd5, 4'd7, 16'hF0F0, 16'h0F00);
    op_case("R5 xor", 4'd6, 4'd8, 16'hF0F0, 16'hFF00);
    op_case("R5 and-not", 4'd7, 4'd8, 16'hF0F0, 16'hFF00);
    op_case("R5 not b", 4'd8, 4'd9, 16'hF0F0, 16'h00FF);
  endtask

  task automatic t_shift();
    op_case("R6 shift left", 4'd11, 4'd10, 16'h8004, 16'hFFFF);
    op_case("R6 logical right", 4'd12, 4'd10, 16'h8004, 16'hFFFF);
    op_case("R6 arithmetic right", 4'd13, 4'd11, 16'h8004, 16'hFFFF);
    op_case("R6 arithmetic right positive", 4'd13, 4'd11, 16'h4004, 16'hFFFF);
  endtask

  task automatic t_hold_clear();
    op_case("R7 pass a ignores bus", 4'd14, 4'd12, 16'hBEEF, 16'h1111);
    op_case("R7 clear", 4'd15, 4'd15, 16'hBEEF, 16'h1111);
  endtask

  task automatic t_read();
    logic [15:0] q;
    bus_write(BASE, 4'd0, 4'd13, 16'hC0DE, 1);
    bus_read(4'd15, 4'd13, q);
    check("R8 read with clear code returns data", q, 16'hC0DE);
    bus_read(4'd0, 4'd13, q);
    check("R8 read did not clear", q, 16'hC0DE);
    @(negedge clk);
    addr = {BASE, 4'd0, 4'd13}; rd = 1'b0;
    #1 check("R9 float with read low", bus, 16'hzzzz);
    addr = {BASE ^ 8'h10, 4'd0, 4'd13}; rd = 1'b1;
    #1 check("R9 float on address miss", bus, 16'hzzzz);
    rd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_window();
    t_select();
    t_arith();
    t_logic();
    t_shift();
    t_hold_clear();
    t_read();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule